// File: doc/BRIEF.md
# CAN receive mailbox matcher

This block sits behind a CAN receiver and takes over once a frame has passed validation. The frame arrives as one strobe carrying its identifier, format bit, remote bit, length code and payload. The block compares the frame against an array of message buffers and picks the one that keeps it. It writes the frame into that buffer, sets the buffer's status code and sends a one-cycle interrupt pulse for that buffer. A frame that no buffer accepts is dropped without any trace.

Two filtering schemes are available, chosen by a mode input. When the mode input is low, the legacy scheme applies. One shared mask covers every buffer except the last two, and each of those two has a dedicated mask. Only the lowest matching buffer is used, and if it still holds an unread frame it is overwritten and flagged as overrun. When the mode input is high, each buffer uses its own mask, and a frame moves on to the next matching buffer that is empty. Only when every matching buffer is occupied is the highest of them overwritten. A separate input suppresses frames the node sent itself.

Buffers are loaded and inspected through a simple indexed write port and a combinational read port. The shared and dedicated masks and the mode bits are plain inputs held by the surrounding register block. That register block clears the mode bit at reset.

Top module: `can_rx_mbox_match`

## Requirements
- R1: After reset every buffer status code reads 4'b0000 (inactive), every stored field reads zero, `busy` is low and `mb_irq` is all zero.
- R2: Only buffers whose code is 4'b0100 (empty), 4'b0010 (full) or 4'b0110 (overrun) take part in matching. The buffer's format bit must equal the frame's format bit. A standard frame compares identifier bits [10:0] and an extended frame compares bits [28:0]. A mask bit of 1 forces the identifier bit to match and a mask bit of 0 ignores it.
- R3: With `cfg_queue_mode` = 0, buffers 0 to N-3 are filtered with `glb_mask`, buffer N-2 with `mask_a` and buffer N-1 with `mask_b`. The per-buffer masks have no effect in this mode.
- R4: With `cfg_queue_mode` = 0, only the lowest-index matching buffer is used. If its code was empty it becomes full (4'b0010). If it was full or overrun it is overwritten and becomes overrun (4'b0110).
- R5: With `cfg_queue_mode` = 1, each buffer is filtered with its own mask, and the frame goes to the lowest-index matching buffer whose code is empty. That buffer becomes full.
- R6: With `cfg_queue_mode` = 1, when no matching buffer is empty, the highest-index matching buffer is overwritten and becomes overrun.
- R7: With `cfg_srx_dis` = 1, a frame flagged `rx_self` is never stored and produces no interrupt pulse or busy period. Frames not flagged are unaffected.
- R8: A store writes the identifier, remote bit, length code, payload and a timestamp into the chosen buffer. The timestamp comes from a free-running 16-bit counter sampled at the accepting edge, so two stores differ in timestamp by the number of clocks between their accepting edges.
- R9: A store raises the chosen buffer's bit of `mb_irq` for exactly one cycle. No bit rises for a dropped frame.
- R10: `busy` is high for exactly the two cycles after the edge that accepts `rx_valid`. The stored result and the interrupt pulse appear after the second edge that follows the accepting edge.
- R11: `rx_valid` is ignored while `busy` is high, and a frame that matches no buffer changes no buffer.
- R12: A configuration write sets the code, identifier, format bit and per-buffer mask of buffer `cfg_idx` and leaves its payload, length and timestamp alone. If it hits the buffer being stored in the same cycle, the store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_queue_mode | input | 1 | 1 = per-buffer masks with queueing, 0 = legacy global masking |
| cfg_srx_dis | input | 1 | Drop frames sent by this node |
| glb_mask | input | IDW | Legacy shared identifier mask |
| mask_a | input | IDW | Legacy mask for buffer N-2 |
| mask_b | input | IDW | Legacy mask for buffer N-1 |
| cfg_we | input | 1 | Buffer configuration write strobe |
| cfg_idx | input | IDXW | Buffer index for the configuration write |
| cfg_code | input | 4 | Status code to write |
| cfg_id | input | IDW | Filter identifier to write |
| cfg_ide | input | 1 | Format bit to write (1 = extended) |
| cfg_mask | input | IDW | Per-buffer mask to write |
| rx_valid | input | 1 | Validated frame strobe |
| rx_self | input | 1 | Frame was transmitted by this node |
| rx_id | input | IDW | Frame identifier (standard in bits [10:0]) |
| rx_ide | input | 1 | Frame format bit |
| rx_rtr | input | 1 | Frame remote bit |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | DW | Frame payload |
| rd_idx | input | IDXW | Buffer index for the read port |
| rd_code | output | 4 | Status code of the indexed buffer |
| rd_id | output | IDW | Identifier of the indexed buffer |
| rd_ide | output | 1 | Format bit of the indexed buffer |
| rd_rtr | output | 1 | Stored remote bit |
| rd_dlc | output | 4 | Stored length code |
| rd_data | output | DW | Stored payload |
| rd_ts | output | TSW | Stored timestamp |
| busy | output | 1 | Match and store in progress |
| mb_irq | output | N | One-cycle per-buffer store pulse |

## Verification
The bench builds the block with its default parameters: sixteen buffers, 29-bit identifiers with an 11-bit standard field, and a 64-bit payload. With these values, buffers 14 and 15 are the ones with dedicated legacy masks. A behavioural model predicts the pick for every frame in both modes. The stimulus covers a chain of three queued buffers that ends in an overrun of the highest match, excluded transmit and inactive codes, format-bit mismatches and don't-care mask bits. It also covers dropped self-sent frames and a second strobe landing during a busy period.

// File: rtl/can_mbox_pkg.sv
`timescale 1ns/1ps
package can_mbox_pkg;

  localparam logic [3:0] MB_INACTIVE = 4'b0000;
  localparam logic [3:0] MB_FULL     = 4'b0010;
  localparam logic [3:0] MB_EMPTY    = 4'b0100;
  localparam logic [3:0] MB_OVERRUN  = 4'b0110;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WR   = 2'd2
  } scan_st_e;

  function automatic logic code_takes_rx(input logic [3:0] c);
    return (c == MB_EMPTY) || (c == MB_FULL) || (c == MB_OVERRUN);
  endfunction

endpackage

// File: rtl/can_id_cmp.sv
`timescale 1ns/1ps
module can_id_cmp
  import can_mbox_pkg::*;
#(
  parameter int IDW  = 29,
  parameter int STDW = 11
) (
  input  logic [IDW-1:0] frm_id,
  input  logic           frm_ide,
  input  logic [IDW-1:0] slot_id,
  input  logic           slot_ide,
  input  logic [IDW-1:0] slot_mask,
  input  logic [3:0]     slot_code,
  output logic           hit,
  output logic           vacant
);

  logic [IDW-1:0] diff;
  logic           id_eq;

  always_comb begin
    diff  = (frm_id ^ slot_id) & slot_mask;
    id_eq = frm_ide ? (diff == '0) : (diff[STDW-1:0] == '0);
    hit   = code_takes_rx(slot_code) && (frm_ide == slot_ide) && id_eq;
    vacant = (slot_code == MB_EMPTY);
  end

endmodule

// File: rtl/can_mbox_pick.sv
`timescale 1ns/1ps
module can_mbox_pick #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    hit_vec,
  input  logic [N-1:0]    vacant_vec,
  input  logic            queue_mode,
  output logic            sel_v,
  output logic [IDXW-1:0] sel_idx,
  output logic            sel_ovr
);

  logic [N-1:0]    free_vec;
  logic            first_v, free_v, last_v;
  logic [IDXW-1:0] first_idx, free_idx, last_idx;

  always_comb begin
    free_vec  = hit_vec & vacant_vec;
    first_v   = 1'b0;
    first_idx = '0;
    free_v    = 1'b0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        first_v   = 1'b1;
        first_idx = IDXW'(i);
      end
      if (free_vec[i]) begin
        free_v   = 1'b1;
        free_idx = IDXW'(i);
      end
    end
    last_v   = 1'b0;
    last_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        last_v   = 1'b1;
        last_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    sel_v   = 1'b0;
    sel_idx = '0;
    sel_ovr = 1'b0;
    if (queue_mode) begin
      if (free_v) begin
        sel_v   = 1'b1;
        sel_idx = free_idx;
      end else if (last_v) begin
        sel_v   = 1'b1;
        sel_idx = last_idx;
        sel_ovr = 1'b1;
      end
    end else if (first_v) begin
      sel_v   = 1'b1;
      sel_idx = first_idx;
      sel_ovr = !vacant_vec[first_idx];
    end
  end

endmodule

// File: rtl/can_rx_mbox_match.sv
`timescale 1ns/1ps
module can_rx_mbox_match
  import can_mbox_pkg::*;
#(
  parameter int N    = 16,
  parameter int IDW  = 29,
  parameter int STDW = 11,
  parameter int DW   = 64,
  parameter int TSW  = 16,
  localparam int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_queue_mode,
  input  logic            cfg_srx_dis,
  input  logic [IDW-1:0]  glb_mask,
  input  logic [IDW-1:0]  mask_a,
  input  logic [IDW-1:0]  mask_b,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [3:0]      cfg_code,
  input  logic [IDW-1:0]  cfg_id,
  input  logic            cfg_ide,
  input  logic [IDW-1:0]  cfg_mask,
  input  logic            rx_valid,
  input  logic            rx_self,
  input  logic [IDW-1:0]  rx_id,
  input  logic            rx_ide,
  input  logic            rx_rtr,
  input  logic [3:0]      rx_dlc,
  input  logic [DW-1:0]   rx_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [3:0]      rd_code,
  output logic [IDW-1:0]  rd_id,
  output logic            rd_ide,
  output logic            rd_rtr,
  output logic [3:0]      rd_dlc,
  output logic [DW-1:0]   rd_data,
  output logic [TSW-1:0]  rd_ts,
  output logic            busy,
  output logic [N-1:0]    mb_irq
);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // free-running timestamp
  logic [TSW-1:0] ts_q, ts_d;
  always_comb ts_d = ts_q + TSW'(1);
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ts_q <= '0;
    else            ts_q <= ts_d;
  end

  // control FSM
  scan_st_e st_q, st_d;
  logic     accept;
  logic     store;

  always_comb begin
    accept = (st_q == ST_IDLE) && rx_valid && !(cfg_srx_dis && rx_self);
    st_d   = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_EVAL;
      ST_EVAL: st_d = ST_WR;
      ST_WR:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);

  // latched frame
  logic [IDW-1:0] f_id;
  logic           f_ide, f_rtr;
  logic [3:0]     f_dlc;
  logic [DW-1:0]  f_data;
  logic [TSW-1:0] f_ts;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      f_id   <= '0;
      f_ide  <= 1'b0;
      f_rtr  <= 1'b0;
      f_dlc  <= '0;
      f_data <= '0;
      f_ts   <= '0;
    end else if (accept) begin
      f_id   <= rx_id;
      f_ide  <= rx_ide;
      f_rtr  <= rx_rtr;
      f_dlc  <= rx_dlc;
      f_data <= rx_data;
      f_ts   <= ts_q;
    end
  end

  // buffer storage
  logic [3:0]     code_q [N];
  logic [IDW-1:0] id_q   [N];
  logic           ide_q  [N];
  logic [IDW-1:0] mask_q [N];
  logic           rtr_q  [N];
  logic [3:0]     dlc_q  [N];
  logic [DW-1:0]  data_q [N];
  logic [TSW-1:0] tsb_q  [N];

  logic [3:0]     code_d [N];
  logic [IDW-1:0] id_d   [N];
  logic           ide_d  [N];
  logic [IDW-1:0] mask_d [N];
  logic           rtr_d  [N];
  logic [3:0]     dlc_d  [N];
  logic [DW-1:0]  data_d [N];
  logic [TSW-1:0] tsb_d  [N];

  // parallel compare against every buffer
  logic [N-1:0] hit_vec, vacant_vec;

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    logic [IDW-1:0] legacy_m;
    logic [IDW-1:0] eff_m;
    if (gi == N - 1) begin : g_lb
      assign legacy_m = mask_b;
    end else if (gi == N - 2) begin : g_la
      assign legacy_m = mask_a;
    end else begin : g_lg
      assign legacy_m = glb_mask;
    end
    assign eff_m = cfg_queue_mode ? mask_q[gi] : legacy_m;

    can_id_cmp #(.IDW(IDW), .STDW(STDW)) u_cmp (
      .frm_id    (f_id),
      .frm_ide   (f_ide),
      .slot_id   (id_q[gi]),
      .slot_ide  (ide_q[gi]),
      .slot_mask (eff_m),
      .slot_code (code_q[gi]),
      .hit       (hit_vec[gi]),
      .vacant    (vacant_vec[gi])
    );
  end

  logic            sel_v, sel_ovr;
  logic [IDXW-1:0] sel_idx;

  can_mbox_pick #(.N(N), .IDXW(IDXW)) u_pick (
    .hit_vec    (hit_vec),
    .vacant_vec (vacant_vec),
    .queue_mode (cfg_queue_mode),
    .sel_v      (sel_v),
    .sel_idx    (sel_idx),
    .sel_ovr    (sel_ovr)
  );

  logic            sel_v_q, sel_ovr_q;
  logic [IDXW-1:0] sel_idx_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_v_q   <= 1'b0;
      sel_ovr_q <= 1'b0;
      sel_idx_q <= '0;
    end else if (st_q == ST_EVAL) begin
      sel_v_q   <= sel_v;
      sel_ovr_q <= sel_ovr;
      sel_idx_q <= sel_idx;
    end
  end

  assign store = (st_q == ST_WR) && sel_v_q;

  // next buffer contents: configuration first, store overrides
  always_comb begin
    code_d = code_q;
    id_d   = id_q;
    ide_d  = ide_q;
    mask_d = mask_q;
    rtr_d  = rtr_q;
    dlc_d  = dlc_q;
    data_d = data_q;
    tsb_d  = tsb_q;
    if (cfg_we) begin
      code_d[cfg_idx] = cfg_code;
      id_d[cfg_idx]   = cfg_id;
      ide_d[cfg_idx]  = cfg_ide;
      mask_d[cfg_idx] = cfg_mask;
    end
    if (store) begin
      code_d[sel_idx_q] = sel_ovr_q ? MB_OVERRUN : MB_FULL;
      id_d[sel_idx_q]   = f_id;
      rtr_d[sel_idx_q]  = f_rtr;
      dlc_d[sel_idx_q]  = f_dlc;
      data_d[sel_idx_q] = f_data;
      tsb_d[sel_idx_q]  = f_ts;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < N; i++) begin
        code_q[i] <= MB_INACTIVE;
        id_q[i]   <= '0;
        ide_q[i]  <= 1'b0;
        mask_q[i] <= '0;
        rtr_q[i]  <= 1'b0;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
        tsb_q[i]  <= '0;
      end
    end else if (cfg_we || store) begin
      code_q <= code_d;
      id_q   <= id_d;
      ide_q  <= ide_d;
      mask_q <= mask_d;
      rtr_q  <= rtr_d;
      dlc_q  <= dlc_d;
      data_q <= data_d;
      tsb_q  <= tsb_d;
    end
  end

  // interrupt pulse
  logic [N-1:0] irq_q, irq_d;
  always_comb begin
    irq_d = '0;
    if (store) irq_d[sel_idx_q] = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= '0;
    else            irq_q <= irq_d;
  end
  assign mb_irq = irq_q;

  // read port
  assign rd_code = code_q[rd_idx];
  assign rd_id   = id_q[rd_idx];
  assign rd_ide  = ide_q[rd_idx];
  assign rd_rtr  = rtr_q[rd_idx];
  assign rd_dlc  = dlc_q[rd_idx];
  assign rd_data = data_q[rd_idx];
  assign rd_ts   = tsb_q[rd_idx];

  // R10
  eval_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_EVAL) |=> (st_q == ST_WR));

  // R10
  wr_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_WR) |=> (st_q == ST_IDLE));

  // R9
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(mb_irq));

  // R9
  irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|mb_irq) |=> !(|mb_irq));

  // R4
  stored_code_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st_q == ST_WR) && sel_v_q) |=>
      ((code_q[sel_idx_q] == MB_FULL) || (code_q[sel_idx_q] == MB_OVERRUN)));

  // R7
  self_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st_q == ST_IDLE) && rx_valid && cfg_srx_dis && rx_self) |=> !busy);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_EVAL) |=> $stable(f_id));

endmodule

// File: tb/sim_can_rx_mbox_match.sv
`timescale 1ns/1ps
module sim_can_rx_mbox_match;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_queue_mode, cfg_srx_dis;
  logic [28:0] glb_mask, mask_a, mask_b;
  logic        cfg_we;
  logic [3:0]  cfg_idx, cfg_code;
  logic [28:0] cfg_id, cfg_mask;
  logic        cfg_ide;
  logic        rx_valid, rx_self, rx_ide, rx_rtr;
  logic [28:0] rx_id;
  logic [3:0]  rx_dlc;
  logic [63:0] rx_data;
  logic [3:0]  rd_idx;
  logic [3:0]  rd_code, rd_dlc;
  logic [28:0] rd_id;
  logic        rd_ide, rd_rtr;
  logic [63:0] rd_data;
  logic [15:0] rd_ts;
  logic        busy;
  logic [15:0] mb_irq;

  can_rx_mbox_match u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_queue_mode(cfg_queue_mode), .cfg_srx_dis(cfg_srx_dis),
    .glb_mask(glb_mask), .mask_a(mask_a), .mask_b(mask_b),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .cfg_id(cfg_id), .cfg_ide(cfg_ide), .cfg_mask(cfg_mask),
    .rx_valid(rx_valid), .rx_self(rx_self), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rd_idx(rd_idx), .rd_code(rd_code), .rd_id(rd_id), .rd_ide(rd_ide),
    .rd_rtr(rd_rtr), .rd_dlc(rd_dlc), .rd_data(rd_data), .rd_ts(rd_ts),
    .busy(busy), .mb_irq(mb_irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // reference model state
  logic [3:0]  m_code [N];
  logic [28:0] m_id   [N];
  logic        m_ide  [N];
  logic [28:0] m_mask [N];
  logic        m_rtr  [N];
  logic [3:0]  m_dlc  [N];
  logic [63:0] m_data [N];
  int          m_edge [N];
  bit          have_off = 0;
  int          ts_off = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input int i, input logic [28:0] id, input logic ide);
    logic [28:0] mk, d;
    if (!(m_code[i] == 4'b0100 || m_code[i] == 4'b0010 || m_code[i] == 4'b0110)) return 1'b0;
    if (m_ide[i] != ide) return 1'b0;
    if (cfg_queue_mode) mk = m_mask[i];
    else if (i == N - 1) mk = mask_b;
    else if (i == N - 2) mk = mask_a;
    else mk = glb_mask;
    d = (id ^ m_id[i]) & mk;
    if (!ide) d = d & 29'h7FF;
    return d == 29'h0;
  endfunction

  task automatic m_pick(input logic [28:0] id, input logic ide,
                        output int idx, output bit ovr);
    idx = -1;
    ovr = 0;
    if (cfg_queue_mode) begin
      for (int i = 0; i < N; i++)
        if (idx < 0 && m_hit(i, id, ide) && m_code[i] == 4'b0100) idx = i;
      if (idx < 0) begin
        for (int i = 0; i < N; i++) if (m_hit(i, id, ide)) idx = i;
        ovr = 1;
      end
    end else begin
      for (int i = 0; i < N; i++) if (idx < 0 && m_hit(i, id, ide)) idx = i;
      if (idx >= 0) ovr = (m_code[idx] != 4'b0100);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(req, 64'(rd_code), 64'(m_code[i]));
      chk(req, 64'(rd_id), 64'(m_id[i]));
      chk(req, 64'(rd_ide), 64'(m_ide[i]));
      chk("R8", 64'(rd_rtr), 64'(m_rtr[i]));
      chk("R8", 64'(rd_dlc), 64'(m_dlc[i]));
      chk("R8", rd_data, m_data[i]);
      if (m_edge[i] >= 0) begin
        if (!have_off) begin
          ts_off = int'(rd_ts) - m_edge[i];
          have_off = 1;
        end
        chk("R8", 64'(rd_ts), 64'(16'(m_edge[i] + ts_off)));
      end
    end
  endtask

  task automatic cfg(input int idx, input logic [3:0] code, input logic [28:0] id,
                     input logic ide, input logic [28:0] mask);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_code = code; cfg_id = id;
    cfg_ide = ide; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 0;
    m_code[idx] = code; m_id[idx] = id; m_ide[idx] = ide; m_mask[idx] = mask;
  endtask

  task automatic send(input string req, input logic [28:0] id, input logic ide,
                      input logic rtr, input logic [3:0] dlc, input logic [63:0] data,
                      input logic self, input bit extra, input logic [28:0] id2);
    int idx; bit ovr; bit acc; int ev; logic [15:0] eirq;
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc;
    rx_data = data; rx_self = self;
    ev  = cyc;
    acc = !(cfg_srx_dis && self);
    m_pick(id, ide, idx, ovr);
    @(negedge clk);
    if (extra) begin
      rx_id = id2; rx_ide = 1'b0; rx_self = 1'b0; rx_data = ~data;
    end else rx_valid = 0;
    chk("R10", 64'(busy), 64'(acc));
    chk("R9", 64'(mb_irq), 64'h0);
    @(negedge clk);
    rx_valid = 0;
    chk(acc ? "R10" : "R7", 64'(busy), 64'(acc));
    chk("R9", 64'(mb_irq), 64'h0);
    @(negedge clk);
    eirq = (acc && idx >= 0) ? (16'(1) << idx) : 16'h0;
    chk("R10", 64'(busy), 64'h0);
    chk("R9", 64'(mb_irq), 64'(eirq));
    if (acc && idx >= 0) begin
      m_code[idx] = ovr ? 4'b0110 : 4'b0010;
      m_id[idx] = id; m_rtr[idx] = rtr; m_dlc[idx] = dlc;
      m_data[idx] = data; m_edge[idx] = ev;
    end
    @(negedge clk);
    chk("R9", 64'(mb_irq), 64'h0);
    chk("R11", 64'(busy), 64'h0);
    sweep(req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_code[i] = 4'b0000; m_id[i] = '0; m_ide[i] = 0; m_mask[i] = '0;
      m_rtr[i] = 0; m_dlc[i] = '0; m_data[i] = '0; m_edge[i] = -1;
    end
    rst_n = 0;
    cfg_queue_mode = 0; cfg_srx_dis = 0;
    glb_mask = 29'h1FFFFFFF; mask_a = 29'h1FFFFFF0; mask_b = 29'h1FFFFFFF;
    cfg_we = 0; cfg_idx = '0; cfg_code = '0; cfg_id = '0; cfg_ide = 0; cfg_mask = '0;
    rx_valid = 0; rx_self = 0; rx_id = '0; rx_ide = 0; rx_rtr = 0; rx_dlc = '0;
    rx_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", 64'(busy), 64'h0);
    chk("R1", 64'(mb_irq), 64'h0);
    sweep("R1");

    // R12 configuration of buffers
    cfg(0, 4'b0100, 29'h123, 0, 29'h0);
    cfg(3, 4'b0100, 29'h123, 0, 29'h0);
    cfg(1, 4'b1000, 29'h555, 0, 29'h7FF);
    cfg(2, 4'b0100, 29'h555, 1, 29'h0);
    cfg(4, 4'b0000, 29'h321, 0, 29'h7FF);
    sweep("R12");

    // R4 legacy: lowest match becomes full, then overrun
    send("R4", 29'h123, 0, 0, 4'd8, 64'h1122334455667788, 0, 0, 0);
    send("R4", 29'h123, 0, 1, 4'd2, 64'h00000000000000AB, 0, 0, 0);

    // R2 transmit code, format mismatch and inactive code excluded
    send("R2", 29'h555, 0, 0, 4'd1, 64'h5A, 0, 0, 0);
    send("R2", 29'h321, 0, 0, 4'd1, 64'h77, 0, 0, 0);

    // R3 dedicated legacy masks for the top two buffers
    cfg(14, 4'b0100, 29'h1ABCDE0, 1, 29'h0);
    cfg(15, 4'b0100, 29'h1ABCDE7, 1, 29'h0);
    send("R3", 29'h1ABCDE7, 1, 0, 4'd4, 64'hCAFE, 0, 0, 0);
    send("R3", 29'h1ABCDE7, 1, 0, 4'd3, 64'hBEEF, 0, 0, 0);
    glb_mask = 29'h7F0;
    send("R3", 29'h12A, 0, 0, 4'd5, 64'hD00D, 0, 0, 0);
    send("R2", 29'h0000555, 1, 0, 4'd6, 64'hF00F, 0, 0, 0);

    // R11 no match discards; second strobe while busy ignored
    send("R11", 29'h7FF, 0, 0, 4'd1, 64'h1, 0, 0, 0);
    send("R11", 29'h1ABCDE1, 1, 0, 4'd7, 64'hABCD, 0, 1, 29'h123);

    // R7 self reception suppression
    cfg_srx_dis = 1;
    send("R7", 29'h123, 0, 0, 4'd2, 64'h99, 1, 0, 0);
    send("R7", 29'h123, 0, 0, 4'd2, 64'h98, 0, 0, 0);
    cfg_srx_dis = 0;
    send("R7", 29'h123, 0, 0, 4'd2, 64'h97, 1, 0, 0);

    // R5 / R6 queue mode with per-buffer masks
    cfg_queue_mode = 1;
    cfg(3, 4'b0000, 29'h123, 0, 29'h0);
    cfg(5, 4'b0100, 29'h7AA, 0, 29'h7FF);
    cfg(6, 4'b0100, 29'h7AB, 0, 29'h7FE);
    cfg(7, 4'b0100, 29'h7A0, 0, 29'h700);
    send("R5", 29'h7AA, 0, 0, 4'd1, 64'h501, 0, 0, 0);
    send("R5", 29'h7AA, 0, 0, 4'd2, 64'h502, 0, 0, 0);
    send("R5", 29'h7AA, 0, 0, 4'd3, 64'h503, 0, 0, 0);
    send("R6", 29'h7AA, 0, 1, 4'd4, 64'h504, 0, 0, 0);
    send("R6", 29'h7AA, 0, 0, 4'd5, 64'h505, 0, 0, 0);

    // back to legacy: per-buffer masks no longer apply
    cfg_queue_mode = 0;
    send("R3", 29'h7AA, 0, 0, 4'd6, 64'h506, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule